// File: doc/BRIEF.md
# Low-Power ADC Conversion Sequencer

This block schedules the conversions an abstract analog-to-digital converter performs. One accepted start pulse triggers a single pass over a set of positions. Each position that is enabled in a channel mask yields one conversion. The block then waits for the next start. The converter is driven through a channel select, a one-cycle request and a power enable. It answers with a one-cycle done strobe and a result word. Each result leaves the block with its channel number, a valid strobe and a last-of-pass flag, ready for a DMA engine or a register file. No placeholder entries appear in that stream.

Two modes set what a position means. In plain mode, position k is channel k, so the pass visits enabled channels from the lowest index up. In user-order mode, position k is a slot whose 4-bit field names a channel. Slots may name channels in any order and may repeat one, and the mask bit of a slot decides whether that slot runs. In low-power mode, the converter is unpowered while idle. A start switches it on, waits a programmable settling count, runs the pass, and switches it off again. The mask, the mode and the power setting are captured when a start is accepted, so later writes affect only the next pass.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The enable mask resets to zero. A 1 on bit k of `ch_en_set` sets mask bit k and a 1 on `ch_en_clr` clears it. When both name the same bit in the same cycle, the set wins. The new mask appears on `ch_en_mask` one cycle later.
- R2: With `cfg_user_mode` low, one conversion runs for each set mask bit, in ascending bit order, and the channel number is the bit index. The pass ends after the highest set bit.
- R3: With `cfg_user_mode` high, slot k converts the channel in `slot_chan[4k+3:4k]`. Slots run in ascending k, and channels may be out of order or repeated.
- R4: A position whose mask bit is clear is skipped with no conversion and no result. The number of results equals the number of set mask bits, so clearing bit 15 in user-order mode drops the last slot.
- R5: One start produces exactly one pass. `seq_done` is a one-cycle pulse that coincides with the final result, and the block is then idle.
- R6: A start that arrives while `seq_busy` is high is ignored. It adds no conversion and no second done pulse.
- R7: `res_valid` pulses in the cycle after each `conv_done`. It carries `res_data` equal to the `conv_data` sampled with that strobe and `res_chan` equal to the converted channel. `res_last` is high only with the final result of a pass.
- R8: A start with an all-zero mask raises `seq_done` in the next cycle. It produces no `conv_req` and no `res_valid`.
- R9: With `cfg_sleep` high, `conv_pwr` is low while idle and rises in the cycle after the start. The first `conv_req` comes exactly `startup_cnt`+1 cycles after that rise, and `conv_pwr` is low again in the cycle of `seq_done`.
- R10: With `cfg_sleep` low, `conv_pwr` stays high, and the first `conv_req` comes in the cycle after the start.
- R11: `conv_req` lasts one cycle per conversion, and `conv_sel` holds its value from the request until the matching done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for one pass |
| cfg_user_mode | input | 1 | 1: positions are slots naming channels |
| cfg_sleep | input | 1 | 1: power the converter only during a pass |
| startup_cnt | input | 8 | Settling wait before the first request in low-power mode |
| ch_en_set | input | 16 | Per-bit mask set strobes |
| ch_en_clr | input | 16 | Per-bit mask clear strobes |
| ch_en_mask | output | 16 | Current enable mask |
| slot_chan | input | 64 | Sixteen 4-bit slot fields, slot k at bits 4k+3:4k |
| conv_pwr | output | 1 | Converter power enable |
| conv_sel | output | 4 | Channel to convert |
| conv_req | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | One-cycle conversion complete strobe |
| conv_data | input | 12 | Converter result |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Channel tag of the result |
| res_data | output | 12 | Result value |
| res_last | output | 1 | Final result of the pass |
| seq_busy | output | 1 | A pass is in progress |
| seq_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest case to reach from the ports is a start pulse landing while a pass is still converting. The bench models a converter that answers every request after a fixed latency. It then fires a second start a few cycles into a running pass and confirms that the result count, the done count and the request count stay at their single-pass values. A user-order slot table with bit 15 cleared, together with a zero-length settling wait, covers the shortened pass and the shortest power-up path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned SEQ_POS   = 16;
    localparam int unsigned SEQ_CH_W  = 4;
    localparam int unsigned SEQ_RES_W = 12;
    localparam int unsigned SEQ_SU_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAKE = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_FIN  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic user;
        logic sleep;
    } seq_mode_t;

endpackage

// File: rtl/adc_seq_enmask.sv
module adc_seq_enmask #(
    parameter int unsigned NUM_POS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_POS-1:0] set_bits,
    input  logic [NUM_POS-1:0] clr_bits,
    output logic [NUM_POS-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else begin
            mask <= (mask & ~clr_bits) | set_bits;
        end
    end
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int unsigned NUM_POS = 16,
    localparam int unsigned IDX_W = $clog2(NUM_POS)
) (
    input  logic [NUM_POS-1:0] vec,
    input  logic [IDX_W-1:0]   from_idx,
    input  logic               incl,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_POS - 1; i >= 0; i--) begin
            if (vec[i] && ((i > int'(from_idx)) || (incl && (i == int'(from_idx))))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_seq_wake.sv
module adc_seq_wake #(
    parameter int unsigned SU_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SU_W-1:0] load_val,
    input  logic            run,
    output logic            expired
);
    logic [SU_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_POS = SEQ_POS,
    parameter int unsigned CH_W    = SEQ_CH_W,
    parameter int unsigned RES_W   = SEQ_RES_W,
    parameter int unsigned SU_W    = SEQ_SU_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cfg_user_mode,
    input  logic                    cfg_sleep,
    input  logic [SU_W-1:0]         startup_cnt,
    input  logic [NUM_POS-1:0]      ch_en_set,
    input  logic [NUM_POS-1:0]      ch_en_clr,
    output logic [NUM_POS-1:0]      ch_en_mask,
    input  logic [NUM_POS*CH_W-1:0] slot_chan,
    output logic                    conv_pwr,
    output logic [CH_W-1:0]         conv_sel,
    output logic                    conv_req,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    output logic                    res_valid,
    output logic [CH_W-1:0]         res_chan,
    output logic [RES_W-1:0]        res_data,
    output logic                    res_last,
    output logic                    seq_busy,
    output logic                    seq_done
);
    localparam int unsigned IDX_W = $clog2(NUM_POS);

    seq_state_e         st_q, st_d;
    seq_mode_t          mode_q;
    logic [NUM_POS-1:0] snap_q;
    logic [IDX_W-1:0]   cur_q;
    logic               first_found, next_found, wake_expired, accept;
    logic [IDX_W-1:0]   first_idx, next_idx;
    logic [CH_W-1:0]    slot_arr [NUM_POS];
    logic [CH_W-1:0]    sel_ch;

    for (genvar k = 0; k < NUM_POS; k++) begin : g_slot
        assign slot_arr[k] = slot_chan[k*CH_W +: CH_W];
    end

    adc_seq_enmask #(.NUM_POS(NUM_POS)) i_enmask (
        .clk      (clk),
        .rst      (rst),
        .set_bits (ch_en_set),
        .clr_bits (ch_en_clr),
        .mask     (ch_en_mask)
    );

    adc_seq_pick #(.NUM_POS(NUM_POS)) i_pick_first (
        .vec      (ch_en_mask),
        .from_idx ('0),
        .incl     (1'b1),
        .found    (first_found),
        .idx      (first_idx)
    );

    adc_seq_pick #(.NUM_POS(NUM_POS)) i_pick_next (
        .vec      (snap_q),
        .from_idx (cur_q),
        .incl     (1'b0),
        .found    (next_found),
        .idx      (next_idx)
    );

    assign accept = (st_q == ST_IDLE) && start;

    adc_seq_wake #(.SU_W(SU_W)) i_wake (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (startup_cnt),
        .run      (st_q == ST_WAKE),
        .expired  (wake_expired)
    );

    assign sel_ch = mode_q.user ? slot_arr[cur_q] : CH_W'(cur_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) begin
                if (!first_found)   st_d = ST_FIN;
                else if (cfg_sleep) st_d = ST_WAKE;
                else                st_d = ST_REQ;
            end
            ST_WAKE: if (wake_expired) st_d = ST_REQ;
            ST_REQ:  st_d = ST_WAIT;
            ST_WAIT: if (conv_done) st_d = next_found ? ST_REQ : ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            mode_q    <= '0;
            snap_q    <= '0;
            cur_q     <= '0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
            res_last  <= 1'b0;
        end else begin
            st_q      <= st_d;
            res_valid <= 1'b0;
            res_last  <= 1'b0;
            if (accept) begin
                mode_q <= '{user: cfg_user_mode, sleep: cfg_sleep};
                snap_q <= ch_en_mask;
                cur_q  <= first_idx;
            end
            if ((st_q == ST_WAIT) && conv_done) begin
                res_valid <= 1'b1;
                res_chan  <= sel_ch;
                res_data  <= conv_data;
                res_last  <= !next_found;
                if (next_found) cur_q <= next_idx;
            end
        end
    end

    always_comb begin
        if (st_q == ST_IDLE)   conv_pwr = !cfg_sleep;
        else if (!mode_q.sleep) conv_pwr = 1'b1;
        else                   conv_pwr = (st_q != ST_FIN);
    end

    assign conv_sel = sel_ch;
    assign conv_req = (st_q == ST_REQ);
    assign seq_busy = (st_q != ST_IDLE);
    assign seq_done = (st_q == ST_FIN);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned CH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            cfg_sleep,
    input logic            conv_req,
    input logic            conv_pwr,
    input logic [CH_W-1:0] conv_sel,
    input logic            conv_done,
    input logic            res_valid,
    input logic            res_last,
    input logic            seq_busy,
    input logic            seq_done
);
    AST_REQ_POWERED: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> conv_pwr); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req); // R11
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> $stable(conv_sel)); // R11
    AST_RES_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(conv_done)); // R7
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        res_last |-> (res_valid && seq_done)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done); // R5
    AST_IDLE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        (!seq_busy && cfg_sleep) |-> !conv_pwr); // R9
    AST_IDLE_POWERED: assert property (@(posedge clk) disable iff (rst)
        (!seq_busy && !cfg_sleep) |-> conv_pwr); // R10
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && !seq_done && start) |=> seq_busy); // R6
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_sleep (cfg_sleep),
    .conv_req  (conv_req),
    .conv_pwr  (conv_pwr),
    .conv_sel  (conv_sel),
    .conv_done (conv_done),
    .res_valid (res_valid),
    .res_last  (res_last),
    .seq_busy  (seq_busy),
    .seq_done  (seq_done)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    typedef struct packed {
        logic        user;
        logic        sleep;
        logic [7:0]  su;
        logic [15:0] mask;
        logic [63:0] slots;
        logic [4:0]  n;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd0, 16'h0025, 64'h0,                   5'd3,  64'h520},
        '{1'b0, 1'b1, 8'd3, 16'h8001, 64'h0,                   5'd2,  64'hF0},
        '{1'b1, 1'b0, 8'd0, 16'h000F, 64'hC377,                5'd4,  64'hC377},
        '{1'b1, 1'b1, 8'd0, 16'h7FFF, 64'h0123456789ABCDEF,    5'd15, 64'h0123456789ABCDEF},
        '{1'b1, 1'b0, 8'd5, 16'h0A00, 64'h5555255555555555,    5'd2,  64'h25}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_user_mode = 1'b0;
    logic        cfg_sleep = 1'b0;
    logic [7:0]  startup_cnt = '0;
    logic [15:0] ch_en_set = '0;
    logic [15:0] ch_en_clr = '0;
    logic [15:0] ch_en_mask;
    logic [63:0] slot_chan = '0;
    logic        conv_pwr, conv_req, conv_done = 1'b0;
    logic [3:0]  conv_sel;
    logic [11:0] conv_data = '0;
    logic        res_valid, res_last, seq_busy, seq_done;
    logic [3:0]  res_chan;
    logic [11:0] res_data;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_user_mode(cfg_user_mode),
        .cfg_sleep(cfg_sleep), .startup_cnt(startup_cnt), .ch_en_set(ch_en_set),
        .ch_en_clr(ch_en_clr), .ch_en_mask(ch_en_mask), .slot_chan(slot_chan),
        .conv_pwr(conv_pwr), .conv_sel(conv_sel), .conv_req(conv_req),
        .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
        .res_chan(res_chan), .res_data(res_data), .res_last(res_last),
        .seq_busy(seq_busy), .seq_done(seq_done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int res_n, req_n, done_n, iss_n, first_req, pwr_rise, done_cyc, pwr_bad;
    logic        pwr_prev, pwr_at_done;
    logic [3:0]  got_ch [32];
    logic [11:0] got_d  [32];
    logic        got_l  [32];
    logic [11:0] iss_d  [32];
    int          lat = 0;
    logic [3:0]  sel_q = '0;
    logic [7:0]  cnv_cnt = 8'h40;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        res_n = 0; req_n = 0; done_n = 0; iss_n = 0;
        first_req = -1; pwr_rise = -1; done_cyc = -1; pwr_bad = 0;
        pwr_prev = conv_pwr; pwr_at_done = 1'b1;
    endtask

    initial forever @(posedge clk) cyc++;

    // converter model and output monitor, both at the falling edge
    initial forever @(negedge clk) begin
        if (conv_pwr && !pwr_prev && pwr_rise < 0) pwr_rise = cyc;
        pwr_prev = conv_pwr;
        if (!cfg_sleep && !conv_pwr) pwr_bad++;
        if (res_valid && res_n < 32) begin
            got_ch[res_n] = res_chan; got_d[res_n] = res_data; got_l[res_n] = res_last;
            res_n++;
        end
        if (seq_done) begin done_n++; done_cyc = cyc; pwr_at_done = conv_pwr; end
        conv_done = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                conv_done = 1'b1;
                conv_data = {sel_q, cnv_cnt};
                if (iss_n < 32) iss_d[iss_n] = conv_data;
                iss_n++;
                cnv_cnt++;
            end
        end
        if (conv_req) begin
            req_n++;
            if (first_req < 0) first_req = cyc;
            sel_q = conv_sel;
            lat = 2;
        end
    end

    task automatic write_mask(input logic [15:0] m);
        @(negedge clk); ch_en_clr = '1; ch_en_set = '0;
        @(negedge clk); ch_en_clr = '0; ch_en_set = m;
        @(negedge clk); ch_en_set = '0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 400; t++) begin
            @(posedge clk);
            if (done_n > 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic launch(output int st_cyc);
        repeat (2) @(negedge clk);
        @(posedge clk); #1 clear_stats();
        @(negedge clk); start = 1'b1; st_cyc = cyc;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int st_cyc;
        cfg_sleep = 1'b1;
        clear_stats();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R1", ch_en_mask, 16'h0, "mask after reset");
        chk("R9", conv_pwr, 1'b0, "idle power with sleep on");
        chk("R5", {seq_busy, seq_done, res_valid}, 3'b000, "idle outputs after reset");

        // vector table walk
        for (int vi = 0; vi < NV; vi++) begin
            vec_t v = VECS[vi];
            write_mask(v.mask);
            chk("R1", ch_en_mask, v.mask, "mask programmed");
            cfg_user_mode = v.user; cfg_sleep = v.sleep;
            startup_cnt = v.su; slot_chan = v.slots;
            launch(st_cyc);
            wait_done();
            chk("R5", done_n, 1, "done pulses per start");
            chk("R4", res_n, v.n, "result count");
            chk("R11", req_n, v.n, "request count");
            for (int k = 0; k < int'(v.n); k++) begin
                chk(v.user ? "R3" : "R2", got_ch[k], v.exp[4*k +: 4], "channel order");
                chk("R7", got_d[k], iss_d[k], "result data");
                chk("R7", got_l[k], (k == int'(v.n) - 1), "last flag");
            end
            if (v.sleep) begin
                chk("R9", pwr_rise - st_cyc, 1, "power rise delay");
                chk("R9", first_req - pwr_rise, int'(v.su) + 1, "startup wait");
                chk("R9", pwr_at_done, 1'b0, "power off at done");
                chk("R9", conv_pwr, 1'b0, "power off after pass");
            end else begin
                chk("R10", first_req - st_cyc, 1, "first request delay");
                chk("R10", pwr_bad, 0, "power dropped without sleep");
            end
        end

        // R8: empty mask
        write_mask(16'h0);
        cfg_sleep = 1'b0; cfg_user_mode = 1'b0;
        launch(st_cyc);
        wait_done();
        chk("R8", done_cyc - st_cyc, 1, "empty pass done delay");
        chk("R8", req_n, 0, "empty pass requests");
        chk("R8", res_n, 0, "empty pass results");

        // R6: start while busy
        write_mask(16'h0C00);
        launch(st_cyc);
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk("R6", done_n, 1, "done pulses with extra start");
        chk("R6", res_n, 2, "results with extra start");
        chk("R6", req_n, 2, "requests with extra start");
        chk("R2", {got_ch[0], got_ch[1]}, 8'hAB, "order with extra start");

        // R1: set beats clear in the same cycle
        @(negedge clk); ch_en_set = 16'h0101; ch_en_clr = 16'h0F0F;
        @(negedge clk); ch_en_set = '0; ch_en_clr = '0;
        chk("R1", ch_en_mask, 16'h0101, "set wins over clear");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule